// File: doc/BRIEF.md
# Initial Reset Controller

This block merges every cause of a system-wide initial reset into one reset line for a small microcontroller that runs from a slow crystal clock. Four causes are merged:

- **Stopped oscillator.** An indication that the slow oscillator has stopped holds reset at once, without waiting for a clock edge.
- **Watchdog.** A watchdog expiry pulse, synchronous to the slow clock, forces reset on the next edge.
- **External reset pin.** This request must pass a noise rejector first.
- **Key combination.** One fixed combination of four key inputs driven high together, chosen at build time by a parameter. This request also passes a noise rejector.

Each noise rejector is a saturating counter. A request only takes effect after it has been seen high on a minimum number of consecutive slow-clock edges; at 32.768 kHz that is about 164 edges, roughly 5 ms.

The pin and the key inputs are asynchronous, so they first pass a short synchronizer. Reset is applied asynchronously by the stopped-oscillator indication and synchronously by the other causes. Reset is always released synchronously. Once the last cause goes away, reset stays asserted for a fixed number of further edges. This gives the rest of the chip a clean release.

Top module: `init_reset_ctrl`

## Requirements
- R1: `KEY_SEL` chooses the key combination. Code 0 means no key reset. Code 1 means `keys_i[0]` and `keys_i[1]` both high. Code 2 means `keys_i[2:0]` all high. Code 3 means all four keys high. Keys outside the selected set are ignored.
- R2: A pin or key request drives `sys_rst_o` high after clock edge n when that request was sampled high at every edge from n-SYNC_STAGES-HOLD_CYCLES through n-SYNC_STAGES-1.
- R3: A request dropped before HOLD_CYCLES consecutive high samples produces no reset. Any low sample restarts the count from zero.
- R4: A watchdog expiry sampled high at an edge drives `sys_rst_o` high after that same edge, with no filtering.
- R5: While `osc_halted_i` is high, `sys_rst_o` is high immediately, without a clock edge. All filter and synchronizer state is cleared during this time.
- R6: After the last edge at which any cause is active, `sys_rst_o` stays high for RELEASE_CYCLES further edges. It is low after the edge that follows those.
- R7: After `osc_halted_i` falls with no other cause active, `sys_rst_o` is high after the first RELEASE_CYCLES edges. It is low after the next edge.
- R8: `sys_rst_o` stays high without a gap for as long as a qualified request stays high.
- R9: With `KEY_SEL` = 0, no pattern or duration on `keys_i` ever changes `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow system clock |
| osc_halted_i | input | 1 | High while the slow oscillator is stopped. Asynchronous reset cause. |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| keys_i | input | 4 | Key inputs used for the combination reset, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous to `clk_i` |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
Each cause has its own latency:

- **Pin or key request:** `sys_rst_o` rises after the edge that follows HOLD_CYCLES high samples plus the SYNC_STAGES synchronizer edges.
- **Watchdog pulse:** `sys_rst_o` is high after the edge that samples the pulse.
- **Stopped oscillator:** `sys_rst_o` is high within the same half cycle.
- **Release:** `sys_rst_o` falls RELEASE_CYCLES+1 edges after the last active cause.

The bench drives inputs and samples `sys_rst_o` on the falling clock edge. For each rising edge it updates a reference model that keeps the run length of consecutive high samples for each cause and the index of the last active edge. Every cycle it compares all four `KEY_SEL` variants against that model.

// File: rtl/init_reset_pkg.sv
package init_reset_pkg;

    localparam int unsigned KEY_COUNT = 4;

    typedef enum logic [1:0] {
        COMBO_OFF   = 2'd0,
        COMBO_TWO   = 2'd1,
        COMBO_THREE = 2'd2,
        COMBO_FOUR  = 2'd3
    } combo_sel_e;

    // Maps a combination code to the set of keys that must all be high.
    function automatic logic [KEY_COUNT-1:0] combo_mask(input int unsigned sel);
        case (sel)
            32'd1:   combo_mask = 4'b0011;
            32'd2:   combo_mask = 4'b0111;
            32'd3:   combo_mask = 4'b1111;
            default: combo_mask = 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/irc_sync.sv
module irc_sync #(
    parameter int unsigned WIDTH  = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) stg_q <= '0;
        else       stg_q <= stg_d;
    end

    assign dout_o = stg_q[STAGES-1];

endmodule

// File: rtl/irc_hold_filter.sv
module irc_hold_filter #(
    parameter int unsigned HOLD_CYCLES = 164
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic req_i,
    output logic qual_o
);

    localparam int unsigned   CW    = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    // Saturating run counter: any low sample restarts it.
    always_comb begin
        cnt_d = cnt_q;
        if (!req_i) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign qual_o = (cnt_q == LIMIT);

    // R3
    restart_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        !req_i |=> (cnt_q == '0));

    // R2
    qual_src_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        $rose(qual_o) |-> $past(req_i));

endmodule

// File: rtl/irc_key_match.sv
module irc_key_match
    import init_reset_pkg::*;
#(
    parameter int unsigned KEY_SEL = 3
) (
    input  logic [KEY_COUNT-1:0] keys_i,
    output logic                 hit_o
);

    localparam logic [KEY_COUNT-1:0] MASK = combo_mask(KEY_SEL);

    assign hit_o = (MASK != '0) && ((keys_i & MASK) == MASK);

endmodule

// File: rtl/irc_release.sv
module irc_release #(
    parameter int unsigned RELEASE_CYCLES = 4
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic act_i,
    output logic rst_o
);

    localparam int unsigned   HW        = $clog2(RELEASE_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_INIT = HW'(RELEASE_CYCLES);

    typedef struct packed {
        logic          rst;
        logic [HW-1:0] hold;
    } rel_t;

    rel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i) begin
            st_d.rst  = 1'b1;
            st_d.hold = HOLD_INIT;
        end else if (st_q.hold != '0) begin
            st_d.rst  = 1'b1;
            st_d.hold = st_q.hold - 1'b1;
        end else begin
            st_d.rst  = 1'b0;
        end
    end

    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) st_q <= '{rst: 1'b1, hold: HOLD_INIT};
        else       st_q <= st_d;
    end

    assign rst_o = st_q.rst;

    // R8
    no_early_release_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        act_i |=> rst_o);

    // R6
    quiet_fall_chk: assert property (@(posedge clk_i) disable iff (clr_i)
        $fell(rst_o) |-> !$past(act_i));

endmodule

// File: rtl/init_reset_ctrl.sv
module init_reset_ctrl
    import init_reset_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES    = 164,
    parameter int unsigned RELEASE_CYCLES = 4,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned KEY_SEL        = 3
) (
    input  logic                 clk_i,
    input  logic                 osc_halted_i,
    input  logic                 rst_pin_i,
    input  logic [KEY_COUNT-1:0] keys_i,
    input  logic                 wdt_expire_i,
    output logic                 sys_rst_o
);

    localparam int unsigned SW = KEY_COUNT + 1;

    logic [SW-1:0]        sync_out;
    logic [KEY_COUNT-1:0] keys_s;
    logic                 pin_s;
    logic                 combo_hit;
    logic                 pin_qual;
    logic                 key_qual;
    logic                 any_act;

    irc_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) i_sync (
        .clk_i  (clk_i),
        .clr_i  (osc_halted_i),
        .din_i  ({keys_i, rst_pin_i}),
        .dout_o (sync_out)
    );

    assign pin_s  = sync_out[0];
    assign keys_s = sync_out[SW-1:1];

    irc_key_match #(.KEY_SEL(KEY_SEL)) i_match (
        .keys_i (keys_s),
        .hit_o  (combo_hit)
    );

    irc_hold_filter #(.HOLD_CYCLES(HOLD_CYCLES)) i_pin_filt (
        .clk_i  (clk_i),
        .clr_i  (osc_halted_i),
        .req_i  (pin_s),
        .qual_o (pin_qual)
    );

    irc_hold_filter #(.HOLD_CYCLES(HOLD_CYCLES)) i_key_filt (
        .clk_i  (clk_i),
        .clr_i  (osc_halted_i),
        .req_i  (combo_hit),
        .qual_o (key_qual)
    );

    // The watchdog pulse skips the noise rejector.
    assign any_act = pin_qual | key_qual | wdt_expire_i;

    irc_release #(.RELEASE_CYCLES(RELEASE_CYCLES)) i_release (
        .clk_i (clk_i),
        .clr_i (osc_halted_i),
        .act_i (any_act),
        .rst_o (sys_rst_o)
    );

    // R4
    wdt_direct_chk: assert property (@(posedge clk_i) disable iff (osc_halted_i)
        wdt_expire_i |=> sys_rst_o);

    // R5
    osc_hold_chk: assert property (@(negedge clk_i)
        osc_halted_i |-> sys_rst_o);

    // R1
    combo_needs_keys_chk: assert property (@(posedge clk_i) disable iff (osc_halted_i)
        $rose(key_qual) |-> $past(combo_hit));

endmodule

// File: tb/test_init_reset_ctrl.sv
module test_init_reset_ctrl;

    localparam int HOLD = 20;
    localparam int REL  = 4;
    localparam int SYN  = 2;

    logic       clk = 1'b0;
    logic       osc_halted = 1'b0;
    logic       pin = 1'b0;
    logic       wdt = 1'b0;
    logic [3:0] keys = 4'b0;
    logic [3:0] rst_o;

    always #4 clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_dut
        init_reset_ctrl #(
            .HOLD_CYCLES(HOLD), .RELEASE_CYCLES(REL),
            .SYNC_STAGES(SYN), .KEY_SEL(g)
        ) i_init_reset_ctrl (
            .clk_i        (clk),
            .osc_halted_i (osc_halted),
            .rst_pin_i    (pin),
            .keys_i       (keys),
            .wdt_expire_i (wdt),
            .sys_rst_o    (rst_o[g])
        );
    end

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    int    n = 0;
    int    pin_run = 0;
    int    key_run [4];
    int    pin_hist [8];
    int    key_hist [4][8];
    int    last_act [4];
    string cur_req = "R5";

    function automatic bit key_hit(int sel, logic [3:0] k);
        case (sel)
            1:       key_hit = k[0] & k[1];
            2:       key_hit = &k[2:0];
            3:       key_hit = &k;
            default: key_hit = 1'b0;
        endcase
    endfunction

    function automatic int slot(int e);
        slot = ((e % 8) + 8) % 8;
    endfunction

    task automatic check_bit(int g, logic exp);
        total++;
        if (rst_o[g] !== exp) begin
            bad++;
            $display("FAIL %s inst%0d edge %0d: actual=%b expected=%b", cur_req, g, n, rst_o[g], exp);
        end
    endtask

    // Reference model for the rising edge that just passed.
    task automatic model_edge();
        n++;
        if (osc_halted) begin
            pin_run = 0;
            for (int s = 0; s < 8; s++) pin_hist[s] = 0;
            for (int g = 0; g < 4; g++) begin
                key_run[g] = 0;
                for (int s = 0; s < 8; s++) key_hist[g][s] = 0;
                last_act[g] = n;
            end
        end else begin
            pin_run = pin ? pin_run + 1 : 0;
            if (pin_run > 100000) pin_run = 100000;
            pin_hist[slot(n)] = pin_run;
            for (int g = 0; g < 4; g++) begin
                key_run[g] = key_hit(g, keys) ? key_run[g] + 1 : 0;
                if (key_run[g] > 100000) key_run[g] = 100000;
                key_hist[g][slot(n)] = key_run[g];
                if (pin_hist[slot(n - SYN - 1)] >= HOLD ||
                    key_hist[g][slot(n - SYN - 1)] >= HOLD || wdt)
                    last_act[g] = n;
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        model_edge();
        for (int g = 0; g < 4; g++) check_bit(g, (n - last_act[g]) <= REL);
    endtask

    task automatic run(int cyc, string req);
        cur_req = req;
        for (int i = 0; i < cyc; i++) step();
    endtask

    task automatic halt_now();
        osc_halted = 1'b1;
        #1;
        cur_req = "R5";
        for (int g = 0; g < 4; g++) check_bit(g, 1'b1);
    endtask

    initial begin
        for (int g = 0; g < 4; g++) begin
            last_act[g] = -100;
            key_run[g] = 0;
            for (int s = 0; s < 8; s++) key_hist[g][s] = 0;
        end
        for (int s = 0; s < 8; s++) pin_hist[s] = 0;
        void'($urandom(32'h5eed_1234));

        #1 halt_now();                       // R5 reset state
        run(3, "R5");
        osc_halted = 1'b0;
        run(REL + 3, "R7");                  // release after oscillator returns

        pin = 1'b1; run(HOLD + SYN + REL + 4, "R2");
        pin = 1'b0; run(REL + SYN + 4, "R6");

        pin = 1'b1; run(HOLD - 1, "R3");     // one sample short
        pin = 1'b0; run(1, "R3");
        pin = 1'b1; run(HOLD - 1, "R3");     // restart after drop
        pin = 1'b0; run(SYN + REL + 4, "R3");

        wdt = 1'b1; run(1, "R4");
        wdt = 1'b0; run(REL + 3, "R4");

        // R1 and R9 (instance 0 must never react to keys)
        foreach (keys[i]) keys[i] = 1'b0;
        for (int p = 0; p < 7; p++) begin
            case (p)
                0: keys = 4'b0011;
                1: keys = 4'b0111;
                2: keys = 4'b1111;
                3: keys = 4'b1011;
                4: keys = 4'b1101;
                5: keys = 4'b0001;
                default: keys = 4'b0110;
            endcase
            run(HOLD + SYN + 5, "R1/R9");
            keys = 4'b0000;
            run(REL + SYN + 4, "R1/R9");
        end

        pin = 1'b1; run(HOLD * 3, "R8");
        halt_now();                          // R5 clears filter state
        run(3, "R5");
        osc_halted = 1'b0;
        run(HOLD + SYN + 6, "R5");
        pin = 1'b0; run(REL + SYN + 4, "R6");

        cur_req = "R2";
        for (int seg = 0; seg < 1500; seg++) begin
            int len;
            len  = $urandom_range(1, 2 * HOLD + 4);
            pin  = ($urandom_range(0, 2) == 0);
            keys = 4'($urandom_range(0, 15));
            if ($urandom_range(0, 150) == 0) begin
                halt_now();
                run(2, "R5");
                osc_halted = 1'b0;
            end
            for (int c = 0; c < len; c++) begin
                wdt = ($urandom_range(0, 59) == 0);
                run(1, "R2");
            end
            wdt = 1'b0;
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule